// File: doc/BRIEF.md
# Interrupt Context Push Engine

When an interrupt is acknowledged, this block writes the interrupted program's context onto a byte-addressed stack. The context is the 20-bit program counter and the 16-bit flag register. A select input chooses which of two stack pointers is used: the user stack or the interrupt stack. The block captures the program counter, the flags, the select input and the chosen pointer on the acknowledge strobe. It then drives a 16-bit memory write port until the four context bytes are stored just below the captured pointer.

The width of each access is chosen at run time from bit 0 of the captured pointer. An even pointer gives two 16-bit word writes. An odd pointer gives four single-byte writes. Each write request is held until the memory answers with ready. After the last write completes, the block hands the pointer, lowered by four, back to the register named by the select. In that same cycle it raises a one-cycle done pulse.

Top module: `ctxSaver`

## Requirements
- R1: Even pointer. With an even captured pointer SP, exactly two writes are issued, both with byte enables 2'b11. The first write goes to word address SP-2 and the second to SP-4.
- R2: Odd pointer. With an odd captured pointer SP, exactly four single-byte writes are issued, to SP-1, SP-2, SP-3 and SP-4 in that order. A byte for an even address travels on memData[7:0] with memBe=2'b01. A byte for an odd address travels on memData[15:8] with memBe=2'b10.
- R3: Byte layout, listed by the byte address each value ends up at:
  - SP-4 holds PC[7:0].
  - SP-3 holds PC[15:8].
  - SP-2 holds FLG[7:0].
  - SP-1 holds {FLG[15:12], PC[19:16]}.
- R4: Only the four bytes from SP-4 to SP-1 are written. SP-5 and SP are left unchanged.
- R5: Exactly one pointer write-back happens per save. It carries SP-4 on spWrData and routes it with spWrSel equal to the captured select.
- R6: Pointer selection. stkSel=1 selects the user pointer uspIn, and stkSel=0 selects the interrupt pointer ispIn. The pointer that was not selected is never written.
- R7: While memReady is low, a pending request keeps memReq, memAddr, memData and memBe unchanged. The pointer write-back comes only after the final write has been accepted.
- R8: Changes on pcIn, flgIn, stkSel, uspIn or ispIn after the acknowledge cycle do not affect the save in progress.
- R9: An acknowledge that arrives while busy is high is ignored. This includes the cycle in which done is high. Such an acknowledge starts no further writes.
- R10: done is a single-cycle pulse that occurs together with spWrEn. busy is high from the cycle after an accepted acknowledge up to and including the done cycle.
- R11: During and right after reset, memReq, spWrEn, done and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intAck | input | 1 | Interrupt acknowledge strobe |
| pcIn | input | 20 | Program counter to save |
| flgIn | input | 16 | Flag register to save |
| stkSel | input | 1 | 1 selects the user pointer, 0 the interrupt pointer |
| uspIn | input | 20 | User stack pointer |
| ispIn | input | 20 | Interrupt stack pointer |
| memReq | output | 1 | Write request valid |
| memAddr | output | 20 | Byte address of the write |
| memData | output | 16 | Write data, lane 0 in [7:0], lane 1 in [15:8] |
| memBe | output | 2 | Byte-lane enables |
| memReady | input | 1 | Memory accepts the current request |
| spWrEn | output | 1 | Pointer write-back strobe |
| spWrSel | output | 1 | Target of the write-back, 1 for user, 0 for interrupt |
| spWrData | output | 20 | New pointer value |
| done | output | 1 | Save complete pulse |
| busy | output | 1 | Save in progress |

## Verification
Two events can fall in the same cycle: the completion of a save, where done and the pointer write-back occur, and a fresh acknowledge. The bench provokes this by holding intAck high for the whole of some saves and dropping it only once done has been seen. In those same saves it also scrambles the PC, the flags and the select input after the first cycle. The save is judged correct only if exactly one done pulse and one write-back occur, no write follows, and memory holds the bytes of the originally captured context. Ready is stalled in an irregular pattern, so the last acceptance and the acknowledge land in varied cycles across a sweep of even and odd pointers on both stacks.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  // Strobes issued by the sequencer to the datapath
  typedef struct packed {
    logic capture;  // latch context and pointer, clear op index
    logic advance;  // current write accepted, step op index
    logic commit;   // write back the lowered pointer
  } ctxStrobe_t;
endpackage

// File: rtl/ctxCtrl.sv
module ctxCtrl
  import ctx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       intAck,
  input  logic       memReady,
  input  logic       lastOp,
  output ctxStrobe_t strb,
  output logic       memReq,
  output logic       busy,
  output logic       done
);
  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_FIN} state_t;
  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      S_IDLE: if (intAck) begin
        strb.capture = 1'b1;
        stateNext    = S_PUSH;
      end
      S_PUSH: if (memReady) begin
        strb.advance = 1'b1;
        if (lastOp) stateNext = S_FIN;
      end
      S_FIN: begin
        strb.commit = 1'b1;
        stateNext   = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign memReq = (state == S_PUSH);
  assign busy   = (state != S_IDLE);
  assign done   = (state == S_FIN);
endmodule

// File: rtl/ctxDatapath.sv
module ctxDatapath
  import ctx_pkg::*;
#(
  parameter int PC_W   = 20,
  parameter int FLG_W  = 16,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctxStrobe_t        strb,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [FLG_W-1:0]  flgIn,
  input  logic              stkSel,
  input  logic [ADDR_W-1:0] uspIn,
  input  logic [ADDR_W-1:0] ispIn,
  output logic              lastOp,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic [DATA_W/8-1:0] memBe,
  output logic              spWrEn,
  output logic              spWrSel,
  output logic [ADDR_W-1:0] spWrData
);
  localparam int LANES    = DATA_W / 8;
  localparam int IMG_B    = 4;
  localparam int IDX_W    = $clog2(IMG_B);
  localparam int IMG_W    = IMG_B * 8;

  logic [PC_W-1:0]   pcQ;
  logic [7:0]        flgLoQ;
  logic [3:0]        flgHiQ;
  logic [ADDR_W-1:0] spBaseQ;
  logic              selQ, oddQ;
  logic [IDX_W-1:0]  idxQ;
  logic [ADDR_W-1:0] spPick;
  logic              unusedFlgMid;

  assign spPick       = stkSel ? uspIn : ispIn;
  assign unusedFlgMid = ^flgIn[11:8];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ <= '0; flgLoQ <= '0; flgHiQ <= '0;
      spBaseQ <= '0; selQ <= 1'b0; oddQ <= 1'b0; idxQ <= '0;
    end else if (strb.capture) begin
      pcQ     <= pcIn;
      flgLoQ  <= flgIn[7:0];
      flgHiQ  <= flgIn[FLG_W-1 -: 4];
      spBaseQ <= spPick;
      selQ    <= stkSel;
      oddQ    <= spPick[0];
      idxQ    <= '0;
    end else if (strb.advance) begin
      idxQ <= idxQ + 1'b1;
    end
  end

  // Context image: byte k lands at address SP-4+k
  logic [IMG_W-1:0] image;
  assign image = {flgHiQ, pcQ[PC_W-1 -: 4], flgLoQ, pcQ[15:0]};

  // Byte offset above SP-4 of the current write
  logic [IDX_W-1:0] offset;
  logic [4:0]       shAmt;
  logic [IMG_W-1:0] shifted;
  assign offset  = oddQ ? (IDX_W'(IMG_B - 1) - idxQ) : {~idxQ[0], 1'b0};
  assign shAmt   = {offset, 3'b000};
  assign shifted = image >> shAmt;
  assign lastOp  = oddQ ? (idxQ == IDX_W'(IMG_B - 1)) : (idxQ == IDX_W'(1));
  assign memAddr = spBaseQ - ADDR_W'(IMG_B) + ADDR_W'(offset);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign memData[l*8 +: 8] = oddQ ? shifted[7:0] : shifted[l*8 +: 8];
    assign memBe[l]          = !oddQ || (memAddr[0] == l[0]);
  end

  assign spWrEn   = strb.commit;
  assign spWrSel  = selQ;
  assign spWrData = spBaseQ - ADDR_W'(IMG_B);
endmodule

// File: rtl/ctxSaver.sv
module ctxSaver
  import ctx_pkg::*;
#(
  parameter int PC_W   = 20,
  parameter int FLG_W  = 16,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                intAck,
  input  logic [PC_W-1:0]     pcIn,
  input  logic [FLG_W-1:0]    flgIn,
  input  logic                stkSel,
  input  logic [ADDR_W-1:0]   uspIn,
  input  logic [ADDR_W-1:0]   ispIn,
  output logic                memReq,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memData,
  output logic [DATA_W/8-1:0] memBe,
  input  logic                memReady,
  output logic                spWrEn,
  output logic                spWrSel,
  output logic [ADDR_W-1:0]   spWrData,
  output logic                done,
  output logic                busy
);
  ctxStrobe_t strb;
  logic       lastOp;

  ctxCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .intAck(intAck), .memReady(memReady),
    .lastOp(lastOp), .strb(strb), .memReq(memReq), .busy(busy), .done(done)
  );

  ctxDatapath #(.PC_W(PC_W), .FLG_W(FLG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pcIn(pcIn), .flgIn(flgIn),
    .stkSel(stkSel), .uspIn(uspIn), .ispIn(ispIn), .lastOp(lastOp),
    .memAddr(memAddr), .memData(memData), .memBe(memBe),
    .spWrEn(spWrEn), .spWrSel(spWrSel), .spWrData(spWrData)
  );
endmodule

// File: rtl/ctxSaverChk.sv
module ctxSaverChk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                memReq,
  input logic                memReady,
  input logic [ADDR_W-1:0]   memAddr,
  input logic [DATA_W-1:0]   memData,
  input logic [DATA_W/8-1:0] memBe,
  input logic                spWrEn,
  input logic                done
);
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memData) && $stable(memBe));

  p_sp_after_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    spWrEn |-> $past(memReq && memReady));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_word_aligned_r1: assert property (@(posedge clk) disable iff (!rstN)
    memReq && (memBe == 2'b11) |-> !memAddr[0]);

  p_byte_lane_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq && (memBe != 2'b11) |-> memBe == (memAddr[0] ? 2'b10 : 2'b01));

  p_no_req_at_commit_r9: assert property (@(posedge clk) disable iff (!rstN)
    spWrEn |-> !memReq);
endmodule

bind ctxSaver ctxSaverChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memReady(memReady),
  .memAddr(memAddr), .memData(memData), .memBe(memBe),
  .spWrEn(spWrEn), .done(done)
);

// File: tb/tb_ctxSaver.sv
`timescale 1ns/1ps
module tb_ctxSaver;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        intAck = 1'b0;
  logic [19:0] pcIn = '0;
  logic [15:0] flgIn = '0;
  logic        stkSel = 1'b0;
  logic [19:0] uspIn, ispIn;
  logic        memReq;
  logic [19:0] memAddr;
  logic [15:0] memData;
  logic [1:0]  memBe;
  logic        memReady = 1'b0;
  logic        spWrEn, spWrSel, done, busy;
  logic [19:0] spWrData;

  always #2.5 clk = ~clk;

  logic [19:0] uspR = '0, ispR = '0;
  assign uspIn = uspR;
  assign ispIn = ispR;

  ctxSaver dut (.*);

  logic [7:0]  mem [0:255];
  logic [19:0] opAddr [0:7];
  logic [1:0]  opBe [0:7];
  int opCnt, doneCnt, spWrites, opsAtCommit, doneMismatch, rdyCnt;
  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory model and observer, evaluated away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      rdyCnt++;
      memReady = ((rdyCnt * 7) % 5) > 1;
      if (memReq && memReady) begin
        if (opCnt < 8) begin
          opAddr[opCnt] = memAddr;
          opBe[opCnt]   = memBe;
        end
        for (int l = 0; l < 2; l++)
          if (memBe[l]) mem[8'({memAddr[7:1], 1'b0}) + 8'(l)] = memData[l*8 +: 8];
        opCnt++;
      end
      if (spWrEn) begin
        opsAtCommit = opCnt;
        spWrites++;
        if (spWrSel) uspR = spWrData; else ispR = spWrData;
      end
      if (done) doneCnt++;
      if (done != spWrEn) doneMismatch++;
    end
  end

  task automatic runSave(input logic [19:0] sp, input bit sel,
                         input logic [19:0] pc, input logic [15:0] flg, input bit hold);
    logic [19:0] other;
    logic [31:0] img;
    int expOps, guard, opsEnd;
    other = sp ^ 20'h00100;
    img = {flg[15:12], pc[19:16], flg[7:0], pc[15:0]};
    expOps = sp[0] ? 4 : 2;
    @(negedge clk); #1;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    if (sel) begin uspR = sp; ispR = other; end
    else     begin ispR = sp; uspR = other; end
    opCnt = 0; doneCnt = 0; spWrites = 0; opsAtCommit = -1; doneMismatch = 0;
    pcIn = pc; flgIn = flg; stkSel = sel; intAck = 1'b1;
    @(negedge clk); #1;
    chk(busy == 1'b1, "R10", "busy after ack", busy, 1);
    if (!hold) intAck = 1'b0;
    else begin
      // R8: scramble captured inputs mid-save
      pcIn = ~pc; flgIn = ~flg; stkSel = ~sel;
    end
    guard = 0;
    while (doneCnt == 0 && guard < 200) begin
      @(negedge clk); #1;
      guard++;
    end
    intAck = 1'b0;
    chk(guard < 200, "R10", "save finished", guard, 0);
    opsEnd = opCnt;
    repeat (4) begin @(negedge clk); #1; end
    chk(opCnt == opsEnd, "R9", "no writes after done", opCnt, opsEnd);
    chk(doneCnt == 1, "R10", "done pulses", doneCnt, 1);
    chk(doneMismatch == 0, "R10", "done with spWrEn", doneMismatch, 0);
    chk(spWrites == 1, "R5", "write-backs", spWrites, 1);
    chk(opsAtCommit == expOps, "R7", "writes before commit", opsAtCommit, expOps);
    chk(opCnt == expOps, sp[0] ? "R2" : "R1", "write count", opCnt, expOps);
    for (int i = 0; i < expOps && i < 8; i++) begin
      if (sp[0]) begin
        chk(opAddr[i] == sp - 20'(1 + i), "R2", "byte addr order", opAddr[i], sp - 20'(1 + i));
        chk(opBe[i] == (((sp - 20'(1 + i)) & 1) != 0 ? 2'b10 : 2'b01), "R2", "byte lane",
            opBe[i], ((sp - 20'(1 + i)) & 1) != 0 ? 2'b10 : 2'b01);
      end else begin
        chk(opAddr[i] == sp - 20'(2 + 2*i), "R1", "word addr order", opAddr[i], sp - 20'(2 + 2*i));
        chk(opBe[i] == 2'b11, "R1", "word enables", opBe[i], 2'b11);
      end
    end
    for (int k = 0; k < 4; k++)
      chk(mem[8'(sp - 20'(4 - k))] == img[8*k +: 8], hold ? "R8" : "R3", "stored byte",
          mem[8'(sp - 20'(4 - k))], img[8*k +: 8]);
    chk(mem[8'(sp - 20'd5)] == (8'(sp - 20'd5) ^ 8'h5A), "R4", "byte below untouched",
        mem[8'(sp - 20'd5)], 8'(sp - 20'd5) ^ 8'h5A);
    chk(mem[8'(sp)] == (8'(sp) ^ 8'h5A), "R4", "byte at SP untouched", mem[8'(sp)], 8'(sp) ^ 8'h5A);
    chk((sel ? uspR : ispR) == sp - 20'd4, "R5", "selected pointer", sel ? uspR : ispR, sp - 20'd4);
    chk((sel ? ispR : uspR) == other, "R6", "other pointer kept", sel ? ispR : uspR, other);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!memReq && !spWrEn && !done && !busy, "R11", "outputs in reset",
        {memReq, spWrEn, done, busy}, 0);
    @(negedge clk); #1;
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(!memReq && !spWrEn && !done && !busy, "R11", "outputs after reset",
        {memReq, spWrEn, done, busy}, 0);
    for (int sp = 16; sp < 48; sp++)
      for (int s = 0; s < 2; s++)
        runSave(20'(sp), s[0], 20'(sp * 20'h1357) ^ 20'hA5C3E,
                16'(sp * 16'h2B1) ^ 16'hF00D ^ 16'(s << 12), ((sp + s) % 3) == 0);
    runSave(20'd200, 1'b1, 20'hFFFFF, 16'hFFFF, 1'b1);
    runSave(20'd201, 1'b0, 20'h00000, 16'h0000, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule